// File: doc/BRIEF.md
# Shared System-Bus Arbiter

This block decides which of several processors owns a shared system bus. Each processor raises its own request line. While the bus is idle the arbiter picks one requester, raises that requester's acknowledge line and sets the bus-busy flag. The owner keeps the bus until it pulses the release input. The bus then returns to idle for one clock, and the next owner is picked on the clock after that.

The priority scheme is fixed when the block is built. In chain mode a row of cells passes a priority token from index 0 to the highest index. A cell keeps the token when its own processor is requesting. In ring mode the same row is closed into a loop, so the token starts at the requester after the most recent owner. In encoder mode a priority encoder turns the request lines into a binary index and a valid flag, and a decoder turns that index into one acknowledge line. The encoder mode picks the same winner as chain mode.

Top module: `sysbus_arbiter`

## Requirements
- R1: After reset, bus busy is 0, no acknowledge is raised, and the ring start pointer is 0, so the first ring grant favours requester 0.
- R2: When the bus is idle and at least one request is high at a clock edge, that edge sets bus busy and raises exactly one acknowledge.
- R3: In chain mode, the owner granted is the requesting line with the lowest index (index 0 is highest priority).
- R4: While bus busy is set and release is low, acknowledge and bus busy hold their values whatever the request lines do.
- R5: A release pulse while busy clears bus busy and all acknowledges at the next edge. A new grant can come no earlier than the edge after that.
- R6: A release pulse while the bus is idle has no effect.
- R7: With the bus idle and no request high, no acknowledge is raised and bus busy stays 0.
- R8: In ring mode, the search starts at the index after the latest owner, wrapping from the top index to 0. The first requester found from there wins.
- R9: In ring mode, with every line requesting continuously, successive owners step through 0,1,2,3,0,… so no line waits more than three tenures.
- R10: In encoder mode, the acknowledge raised is the one-hot decode of the lowest requesting index. No acknowledge is raised when the encoder's valid flag is 0.
- R11: Whenever bus busy is set exactly one acknowledge is high, and whenever it is clear none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_REQ | One request line per processor |
| release_i | input | 1 | Owner gives up the bus (one-cycle pulse) |
| ack_o | output | NUM_REQ | One-hot acknowledge to the current owner |
| busy_o | output | 1 | Bus-busy flag |

## Verification
The hardest case to reach is a ring grant where the start pointer sits high and the only requesters lie below it. The search must then wrap past the top index. The bench steps every request pattern through several release phases, so the pointer lands on each value while many different patterns are offered. A long run with all lines requesting then checks that ownership advances by one each tenure. All three builds are driven from the same inputs and compared each cycle against a model computed in the bench.

// File: rtl/sysbus_arb_pkg.sv
package sysbus_arb_pkg;
    typedef enum logic [1:0] {
        MODE_CHAIN  = 2'd0,
        MODE_RING   = 2'd1,
        MODE_ENCODE = 2'd2
    } arb_mode_e;
endpackage

// File: rtl/sysbus_arb_cell.sv
// One link of the priority chain: keeps the token when its requester wants the bus.
module sysbus_arb_cell (
    input  logic tok_in,
    input  logic want,
    output logic tok_out,
    output logic win
);
    always_comb begin
        win     = tok_in & want;
        tok_out = tok_in & ~want;
    end
endmodule

// File: rtl/sysbus_prio_enc.sv
// Lowest index has the highest priority; valid is low when nothing requests.
module sysbus_prio_enc #(
    parameter int NUM_REQ = 4,
    localparam int IDX_W = $clog2(NUM_REQ)
) (
    input  logic [NUM_REQ-1:0] lines,
    output logic [IDX_W-1:0]   code,
    output logic               valid
);
    always_comb begin
        code  = '0;
        valid = |lines;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (lines[i]) code = IDX_W'(i);
        end
    end
endmodule

// File: rtl/sysbus_onehot_dec.sv
module sysbus_onehot_dec #(
    parameter int NUM_REQ = 4,
    localparam int IDX_W = $clog2(NUM_REQ)
) (
    input  logic [IDX_W-1:0]   code,
    input  logic               en,
    output logic [NUM_REQ-1:0] lines
);
    always_comb begin
        lines = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (en && code == IDX_W'(i)) lines[i] = 1'b1;
        end
    end
endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter
    import sysbus_arb_pkg::*;
#(
    parameter int        NUM_REQ  = 4,
    parameter arb_mode_e ARB_MODE = MODE_RING,
    localparam int IDX_W = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               release_i,
    output logic [NUM_REQ-1:0] ack_o,
    output logic               busy_o
);
    typedef struct packed {
        logic               busy;
        logic [NUM_REQ-1:0] ack;
        logic [IDX_W-1:0]   ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic [NUM_REQ-1:0] win_vec;
    logic               win_any;

    generate
        if (ARB_MODE == MODE_ENCODE) begin : g_encode
            logic [IDX_W-1:0] enc_code;
            logic             enc_valid;
            sysbus_prio_enc #(.NUM_REQ(NUM_REQ)) enc_i (
                .lines(req_i), .code(enc_code), .valid(enc_valid));
            sysbus_onehot_dec #(.NUM_REQ(NUM_REQ)) dec_i (
                .code(enc_code), .en(enc_valid), .lines(win_vec));
            assign win_any = enc_valid;
        end else begin : g_chain
            // Requests viewed from the chain head; the head is index ptr_q.
            logic [NUM_REQ-1:0] rot_req;
            logic [NUM_REQ-1:0] tok;
            logic [NUM_REQ-1:0] rot_win;
            always_comb begin
                for (int k = 0; k < NUM_REQ; k++) begin
                    rot_req[k] = req_i[(int'(st_q.ptr) + k) % NUM_REQ];
                end
            end
            for (genvar k = 0; k < NUM_REQ; k++) begin : g_cell
                logic tok_in;
                if (k == 0) begin : g_head
                    assign tok_in = 1'b1;
                end else begin : g_link
                    assign tok_in = tok[k-1];
                end
                sysbus_arb_cell cell_i (
                    .tok_in(tok_in), .want(rot_req[k]),
                    .tok_out(tok[k]), .win(rot_win[k]));
            end
            // Token leaving the last cell means nobody claimed it.
            assign win_any = ~tok[NUM_REQ-1];
            always_comb begin
                win_vec = '0;
                for (int k = 0; k < NUM_REQ; k++) begin
                    if (rot_win[k]) win_vec[(int'(st_q.ptr) + k) % NUM_REQ] = 1'b1;
                end
            end
        end
    endgenerate

    always_comb begin
        logic [IDX_W-1:0] widx;
        widx = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (win_vec[i]) widx = IDX_W'(i);
        end
        st_d = st_q;
        if (st_q.busy) begin
            if (release_i) begin
                st_d.busy = 1'b0;
                st_d.ack  = '0;
            end
        end else if (win_any) begin
            st_d.busy = 1'b1;
            st_d.ack  = win_vec;
            if (ARB_MODE == MODE_RING) begin
                st_d.ptr = IDX_W'((int'(widx) + 1) % NUM_REQ);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_o  = st_q.ack;
    assign busy_o = st_q.busy;
endmodule

// File: rtl/sysbus_arbiter_chk.sv
module sysbus_arbiter_chk
    import sysbus_arb_pkg::*;
#(
    parameter int        NUM_REQ  = 4,
    parameter arb_mode_e ARB_MODE = MODE_RING
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req_i,
    input logic               release_i,
    input logic [NUM_REQ-1:0] ack_o,
    input logic               busy_o
);
    assert_one_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $countones(ack_o) == 1);
    assert_idle_no_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ack_o == '0);
    assert_grant_on_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i != '0) |=> busy_o);
    assert_grant_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i != '0) |=> (ack_o & $past(req_i)) == ack_o);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !release_i) |=> (busy_o && $stable(ack_o)));
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && release_i) |=> !busy_o);
    assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i == '0) |=> !busy_o);
    generate
        if (ARB_MODE != MODE_RING) begin : g_fixed
            assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!busy_o && req_i != '0) |=>
                    ((ack_o - NUM_REQ'(1)) & $past(req_i)) == '0);
        end
    endgenerate
endmodule

bind sysbus_arbiter sysbus_arbiter_chk #(.NUM_REQ(NUM_REQ), .ARB_MODE(ARB_MODE)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .release_i(release_i),
    .ack_o(ack_o), .busy_o(busy_o));

// File: tb/sysbus_arbiter_tb.sv
module sysbus_arbiter_tb_top;
    import sysbus_arb_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] req = '0;
    logic rel = 1'b0;
    logic [3:0] ack_c, ack_r, ack_e;
    logic busy_c, busy_r, busy_e;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int exp_busy [3];
    int exp_ack  [3];
    int exp_ptr  [3];

    always #5 clk = ~clk;

    sysbus_arbiter #(.NUM_REQ(4), .ARB_MODE(MODE_RING)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .release_i(rel),
        .ack_o(ack_r), .busy_o(busy_r));
    sysbus_arbiter #(.NUM_REQ(4), .ARB_MODE(MODE_CHAIN)) dut_chain_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .release_i(rel),
        .ack_o(ack_c), .busy_o(busy_c));
    sysbus_arbiter #(.NUM_REQ(4), .ARB_MODE(MODE_ENCODE)) dut_enc_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .release_i(rel),
        .ack_o(ack_e), .busy_o(busy_e));

    function automatic int pick(input logic [3:0] r, input int start);
        for (int k = 0; k < 4; k++) begin
            if (r[(start + k) % 4]) return (start + k) % 4;
        end
        return -1;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        if (m == 0) return "R3";
        if (m == 1) return "R8";
        return "R10";
    endfunction

    task automatic compare(input string tag);
        int a [3];
        int b [3];
        a[0] = int'(ack_c); a[1] = int'(ack_r); a[2] = int'(ack_e);
        b[0] = int'(busy_c); b[1] = int'(busy_r); b[2] = int'(busy_e);
        for (int m = 0; m < 3; m++) begin
            string t;
            t = (tag == "") ? mode_tag(m) : tag;
            check(a[m] == exp_ack[m], {t, " ack mode ", m == 0 ? "chain" : m == 1 ? "ring" : "enc"},
                  a[m], exp_ack[m]);
            check(b[m] == exp_busy[m], {t, " busy"}, b[m], exp_busy[m]);
            check(b[m] ? ($countones(a[m]) == 1) : (a[m] == 0), "R11 owner count", a[m], b[m]);
        end
    endtask

    task automatic model_step();
        for (int m = 0; m < 3; m++) begin
            if (exp_busy[m] != 0) begin
                if (rel) begin exp_busy[m] = 0; exp_ack[m] = 0; end
            end else if (req != 4'b0) begin
                int w;
                w = pick(req, (m == 1) ? exp_ptr[m] : 0);
                exp_busy[m] = 1;
                exp_ack[m] = 1 << w;
                if (m == 1) exp_ptr[m] = (w + 1) % 4;
            end
        end
    endtask

    task automatic cyc(input logic [3:0] r, input logic rl, input string tag);
        @(negedge clk);
        req = r;
        rel = rl;
        @(posedge clk);
        model_step();
        #2;
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt [4];
        int last;
        for (int m = 0; m < 3; m++) begin exp_busy[m] = 0; exp_ack[m] = 0; exp_ptr[m] = 0; end
        repeat (3) @(posedge clk);
        #2;
        compare("R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: pointer 0 makes requester 0 win the first ring grant
        cyc(4'b1111, 1'b0, "R1");
        cyc(4'b0000, 1'b1, "R5");
        cyc(4'b0000, 1'b0, "R7");
        cyc(4'b0000, 1'b0, "R7");
        cyc(4'b0000, 1'b1, "R6");
        cyc(4'b0000, 1'b0, "R6");
        cyc(4'b1010, 1'b0, "R2");
        cyc(4'b0101, 1'b0, "R4");
        cyc(4'b1111, 1'b0, "R4");
        cyc(4'b0000, 1'b0, "R4");
        cyc(4'b1111, 1'b1, "R5");
        cyc(4'b1111, 1'b0, "R5");
        cyc(4'b0000, 1'b1, "R5");
        // Sweep every pattern through several release phases.
        for (int p = 0; p < 16; p++) begin
            for (int r = 0; r < 5; r++) begin
                cyc(4'(p ^ (r * 5)), 1'(r % 2), "");
            end
        end
        // Drain to idle.
        cyc(4'b0000, 1'b1, "R5");
        cyc(4'b0000, 1'b0, "R7");
        // R9: all requesting, ring owners advance by one per tenure
        for (int i = 0; i < 4; i++) cnt[i] = 0;
        last = -1;
        for (int g = 0; g < 8; g++) begin
            int now;
            cyc(4'b1111, 1'b0, "R9");
            now = -1;
            for (int i = 0; i < 4; i++) if (ack_r[i]) now = i;
            if (now >= 0) cnt[now]++;
            if (last >= 0) check(now == (last + 1) % 4, "R9 ring step", now, (last + 1) % 4);
            last = now;
            cyc(4'b1111, 1'b1, "R9");
        end
        for (int i = 0; i < 4; i++) check(cnt[i] == 2, "R9 share per requester", cnt[i], 2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule